// File: doc/BRIEF.md
# Atomic Read-Modify-Write Admission Gate

This gate sits in front of a cache request sequencer that is shared by several processors. Each request is presented with the processor's identifier, a request kind and a probe flag. The gate answers combinationally with a ready signal. A processor that opens a read-modify-write sequence becomes the sole owner of the sequencer. While it owns the sequencer, requests from every other processor are refused.

The owner may hold several read-modify-write reads open at once, and a counter tracks them. Each completed read-modify-write write is reported on a separate retirement port and lowers the counter. When the counter returns to zero, ownership lapses. An ordinary request from the owner ends ownership at once.

A probe request gets the same ready answer as a real one but leaves ownership and the counter unchanged. Several events are treated as invariant violations: a retirement from the wrong processor, a retirement when nothing is open, and a request carrying the reserved identifier. Each of these sets a sticky fault output, and a violation never changes ownership or the counter.

Top module: `rmw_admit_gate`

## Requirements
- R1: After reset, `owner_id` reads 200 (the no-owner code), `open_level` reads 0 and `fault` reads 0.
- R2: While an owner is held, `chk_ready` is 0 for any other identifier. With no owner, `chk_ready` is 1 for every identifier except the reserved one, 100.
- R3: A committed read-modify-write read (kind 5) with no owner makes the requester the owner, with `open_level` 1, on the next cycle.
- R4: A committed read-modify-write read from the owner raises `open_level` by one. A request of kind 6 (read-modify-write write) from the owner leaves the owner and the level unchanged. Kind codes are: 0 load, 1 store, 2 instruction fetch, 3 locked read, 4 locked write, 5 read-modify-write read, 6 read-modify-write write.
- R5: A committed request from the owner of any kind other than 5 or 6 returns the owner to 200 and the level to 0.
- R6: A retirement from the owner while `open_level` is non-zero lowers the level by one. When the level reaches 0, the owner becomes 200. `owner_id` is 200 exactly when `open_level` is 0.
- R7: A retirement whose identifier is not the owner, or one that arrives with `open_level` 0, sets `fault` and changes neither the owner nor the level.
- R8: With `chk_probe` high, `chk_ready` is computed as usual, but owner and level do not change.
- R9: A valid request with identifier 100 sees `chk_ready` 0, sets `fault`, and changes no state.
- R10: A read-modify-write read from the owner while `open_level` is 255 sees `chk_ready` 0. The level stays at 255 and `fault` is not set.
- R11: When a request and a retirement arrive in the same cycle, their effects combine. An owner read plus an owner retirement leaves the level unchanged, and an owner release wins over a retirement.
- R12: `fault` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | A request is presented |
| chk_pid | input | 8 | Requesting processor identifier |
| chk_kind | input | 3 | Request kind code |
| chk_probe | input | 1 | Query only, do not update state |
| chk_ready | output | 1 | Request may be accepted this cycle |
| done_valid | input | 1 | A read-modify-write write has retired |
| done_pid | input | 8 | Identifier of the retiring processor |
| owner_id | output | 8 | Current owner, 200 when none |
| open_level | output | 8 | Outstanding read-modify-write reads |
| fault | output | 1 | Sticky invariant-violation flag |

## Verification
The bench builds the gate with its default 8-bit identifier and 8-bit counter. With these widths, the no-owner code 200 and the reserved code 100 are ordinary identifier values. They also make the 255-deep saturation point reachable in a short directed loop of reads, followed by a full drain by retirements. Random traffic over a small set of identifiers produces frequent contention, probes and same-cycle request and retirement collisions.

// File: rtl/rmw_gate_pkg.sv
// Shared request-kind encoding for the admission gate.
// Assumes a 3-bit kind field driven by the sequencer front end.
package rmw_gate_pkg;
    typedef enum logic [2:0] {
        KIND_LOAD    = 3'd0,
        KIND_STORE   = 3'd1,
        KIND_IFETCH  = 3'd2,
        KIND_LOCK_RD = 3'd3,
        KIND_LOCK_WR = 3'd4,
        KIND_RMW_RD  = 3'd5,
        KIND_RMW_WR  = 3'd6,
        KIND_SPARE   = 3'd7
    } req_kind_e;
endpackage

// File: rtl/rmw_admit_decide.sv
// Decides whether a request is admitted and what state change it asks for.
// Purely combinational; assumes owner/level come from the state registers.
module rmw_admit_decide
    import rmw_gate_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int CNT_W     = 8,
    parameter int NONE_ID   = 200,
    parameter int BANNED_ID = 100
) (
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_pid,
    input  logic [2:0]       req_kind,
    input  logic             req_probe,
    input  logic [ID_W-1:0]  cur_owner,
    input  logic [CNT_W-1:0] cur_level,
    output logic             ready,
    output logic             claim,
    output logic             bump,
    output logic             release_own,
    output logic             bad_req
);
    localparam logic [ID_W-1:0]  NONE_V   = ID_W'(NONE_ID);
    localparam logic [ID_W-1:0]  BANNED_V = ID_W'(BANNED_ID);
    localparam logic [CNT_W-1:0] LEVEL_MAX = {CNT_W{1'b1}};

    req_kind_e kind;
    logic      held, foreign, banned, full, is_rd, is_wr, commit;

    // Classify the request against the current ownership.
    always_comb begin
        kind    = req_kind_e'(req_kind);
        held    = (cur_owner != NONE_V);
        foreign = held && (req_pid != cur_owner);
        banned  = (req_pid == BANNED_V);
        full    = (cur_level == LEVEL_MAX);
        is_rd   = (kind == KIND_RMW_RD);
        is_wr   = (kind == KIND_RMW_WR);
    end

    // Produce the ready answer and the committed intents.
    always_comb begin
        ready       = !banned && !foreign && !(is_rd && held && full);
        commit      = req_valid && ready && !req_probe;
        claim       = commit && is_rd && !held;
        bump        = commit && is_rd && held;
        release_own = commit && held && !is_rd && !is_wr;
        bad_req     = req_valid && banned;
    end
endmodule

// File: rtl/rmw_retire_check.sv
// Validates a read-modify-write retirement against the current owner.
// Combinational; a valid retirement needs a held owner with open reads.
module rmw_retire_check #(
    parameter int ID_W    = 8,
    parameter int CNT_W   = 8,
    parameter int NONE_ID = 200
) (
    input  logic             ret_valid,
    input  logic [ID_W-1:0]  ret_pid,
    input  logic [ID_W-1:0]  cur_owner,
    input  logic [CNT_W-1:0] cur_level,
    output logic             drop,
    output logic             bad_ret
);
    localparam logic [ID_W-1:0] NONE_V = ID_W'(NONE_ID);

    logic legal;

    // Accept a retirement only from the owner while reads are open.
    always_comb begin
        legal   = (cur_owner != NONE_V) && (ret_pid == cur_owner) && (cur_level != '0);
        drop    = ret_valid && legal;
        bad_ret = ret_valid && !legal;
    end
endmodule

// File: rtl/rmw_owner_state.sv
// Holds the owner identifier, the open-read level and the sticky fault.
// Assumes claim and drop never coincide (claim needs no owner, drop needs one).
module rmw_owner_state #(
    parameter int ID_W    = 8,
    parameter int CNT_W   = 8,
    parameter int NONE_ID = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  claim_pid,
    input  logic             claim,
    input  logic             bump,
    input  logic             release_own,
    input  logic             drop,
    input  logic             violation,
    output logic [ID_W-1:0]  owner_q,
    output logic [CNT_W-1:0] level_q,
    output logic             fault_q
);
    localparam logic [ID_W-1:0] NONE_V = ID_W'(NONE_ID);

    logic [CNT_W-1:0] level_d;
    logic [ID_W-1:0]  owner_d;

    // Combine increments, decrements and release into the next state.
    always_comb begin
        if (release_own) begin
            level_d = '0;
            owner_d = NONE_V;
        end else begin
            level_d = level_q + CNT_W'(claim || bump) - CNT_W'(drop);
            owner_d = claim ? claim_pid : owner_q;
            if (level_d == '0) owner_d = NONE_V;
        end
    end

    // Register the ownership state and accumulate faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= NONE_V;
            level_q <= '0;
            fault_q <= 1'b0;
        end else begin
            owner_q <= owner_d;
            level_q <= level_d;
            fault_q <= fault_q | violation;
        end
    end
endmodule

// File: rtl/rmw_admit_gate.sv
// Admission gate granting one processor exclusive use of a shared sequencer
// during read-modify-write sequences. Ready is combinational on the request.
module rmw_admit_gate #(
    parameter int ID_W      = 8,
    parameter int CNT_W     = 8,
    parameter int NONE_ID   = 200,
    parameter int BANNED_ID = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic [ID_W-1:0]  chk_pid,
    input  logic [2:0]       chk_kind,
    input  logic             chk_probe,
    output logic             chk_ready,
    input  logic             done_valid,
    input  logic [ID_W-1:0]  done_pid,
    output logic [ID_W-1:0]  owner_id,
    output logic [CNT_W-1:0] open_level,
    output logic             fault
);
    logic claim, bump, release_own, bad_req, drop, bad_ret;

    rmw_admit_decide #(
        .ID_W(ID_W), .CNT_W(CNT_W), .NONE_ID(NONE_ID), .BANNED_ID(BANNED_ID)
    ) u_decide (
        .req_valid  (chk_valid),
        .req_pid    (chk_pid),
        .req_kind   (chk_kind),
        .req_probe  (chk_probe),
        .cur_owner  (owner_id),
        .cur_level  (open_level),
        .ready      (chk_ready),
        .claim      (claim),
        .bump       (bump),
        .release_own(release_own),
        .bad_req    (bad_req)
    );

    rmw_retire_check #(
        .ID_W(ID_W), .CNT_W(CNT_W), .NONE_ID(NONE_ID)
    ) u_retire (
        .ret_valid(done_valid),
        .ret_pid  (done_pid),
        .cur_owner(owner_id),
        .cur_level(open_level),
        .drop     (drop),
        .bad_ret  (bad_ret)
    );

    rmw_owner_state #(
        .ID_W(ID_W), .CNT_W(CNT_W), .NONE_ID(NONE_ID)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim_pid  (chk_pid),
        .claim      (claim),
        .bump       (bump),
        .release_own(release_own),
        .drop       (drop),
        .violation  (bad_req || bad_ret),
        .owner_q    (owner_id),
        .level_q    (open_level),
        .fault_q    (fault)
    );
endmodule

// File: rtl/rmw_admit_gate_sva.sv
// Property checker for the admission gate, bound to the top module.
module rmw_admit_gate_sva #(
    parameter int ID_W      = 8,
    parameter int CNT_W     = 8,
    parameter int NONE_ID   = 200,
    parameter int BANNED_ID = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_valid,
    input logic [ID_W-1:0]  chk_pid,
    input logic [2:0]       chk_kind,
    input logic             chk_probe,
    input logic             chk_ready,
    input logic             done_valid,
    input logic [ID_W-1:0]  done_pid,
    input logic [ID_W-1:0]  owner_id,
    input logic [CNT_W-1:0] open_level,
    input logic             fault
);
    localparam logic [ID_W-1:0] NONE_V = ID_W'(NONE_ID);

    p_stall_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_id != NONE_V && chk_pid != owner_id) |-> !chk_ready);

    p_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready && !chk_probe && chk_kind == 3'd5
         && owner_id == NONE_V && !done_valid)
        |=> (owner_id == $past(chk_pid) && open_level == CNT_W'(1)));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready && !chk_probe && owner_id != NONE_V
         && chk_kind != 3'd5 && chk_kind != 3'd6)
        |=> (owner_id == NONE_V && open_level == '0));

    p_owner_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_id == NONE_V) == (open_level == '0));

    p_bad_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_pid != owner_id) |=> fault);

    p_probe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_probe && !done_valid) |=> ($stable(owner_id) && $stable(open_level)));

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
endmodule

bind rmw_admit_gate rmw_admit_gate_sva #(
    .ID_W(ID_W), .CNT_W(CNT_W), .NONE_ID(NONE_ID), .BANNED_ID(BANNED_ID)
) u_sva (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_pid(chk_pid),
    .chk_kind(chk_kind), .chk_probe(chk_probe), .chk_ready(chk_ready),
    .done_valid(done_valid), .done_pid(done_pid), .owner_id(owner_id),
    .open_level(open_level), .fault(fault)
);

// File: tb/rmw_admit_gate_test.sv
module rmw_admit_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_valid = 1'b0;
    logic [7:0] chk_pid = 8'd0;
    logic [2:0] chk_kind = 3'd0;
    logic       chk_probe = 1'b0;
    logic       chk_ready;
    logic       done_valid = 1'b0;
    logic [7:0] done_pid = 8'd0;
    logic [7:0] owner_id;
    logic [7:0] open_level;
    logic       fault;

    int n_checks = 0;
    int n_fail = 0;
    int m_owner = 200;
    int m_level = 0;
    int m_fault = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rmw_admit_gate uut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_pid(chk_pid),
        .chk_kind(chk_kind), .chk_probe(chk_probe), .chk_ready(chk_ready),
        .done_valid(done_valid), .done_pid(done_pid), .owner_id(owner_id),
        .open_level(open_level), .fault(fault)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_ready(int pid, int kind);
        if (pid == 100) return 0;
        if (m_owner != 200 && pid != m_owner) return 0;
        if (kind == 5 && m_owner != 200 && m_level == 255) return 0;
        return 1;
    endfunction

    task automatic check_state(string req);
        check({req, " owner"}, int'(owner_id), m_owner);
        check({req, " level"}, int'(open_level), m_level);
        check({req, " fault"}, int'(fault), m_fault);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chk_valid = 1'b0; done_valid = 1'b0; chk_probe = 1'b0;
        @(posedge clk); @(posedge clk);
        #1 rst_n = 1'b1;
        m_owner = 200; m_level = 0; m_fault = 0;
        check_state("R1 reset");
    endtask

    // One cycle of stimulus: check ready, predict, then check the state.
    task automatic step(bit v, int pid, int kind, bit probe, bit dv, int dpid, string req);
        int r, nl;
        bit held, commit, drop;
        @(negedge clk);
        chk_valid = v; chk_pid = 8'(pid); chk_kind = 3'(kind); chk_probe = probe;
        done_valid = dv; done_pid = 8'(dpid);
        #1;
        r = exp_ready(pid, kind);
        check({req, " ready"}, int'(chk_ready), r);
        held   = (m_owner != 200);
        commit = v && r && !probe;
        drop   = dv && held && dpid == m_owner && m_level != 0;
        if ((v && pid == 100) || (dv && !drop)) m_fault = 1;
        if (commit && held && kind != 5 && kind != 6) begin
            m_owner = 200; m_level = 0;
        end else begin
            nl = m_level + ((commit && kind == 5) ? 1 : 0) - (drop ? 1 : 0);
            if (commit && kind == 5 && !held) m_owner = pid;
            m_level = nl;
            if (nl == 0) m_owner = 200;
        end
        @(posedge clk);
        #1;
        check_state(req);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        do_reset();
        // R2: no owner, everyone but reserved is ready
        step(0, 7, 0, 0, 0, 0, "R2 idle");
        step(1, 3, 5, 0, 0, 0, "R3 claim");
        step(1, 7, 0, 0, 0, 0, "R2 foreign stall");
        step(1, 7, 5, 0, 0, 0, "R2 foreign rmw stall");
        step(1, 3, 5, 0, 0, 0, "R4 bump");
        step(1, 3, 6, 0, 0, 0, "R4 rmw write keeps");
        step(1, 3, 0, 1, 0, 0, "R8 probe load");
        step(1, 3, 5, 1, 0, 0, "R8 probe rmw");
        step(0, 0, 0, 0, 1, 3, "R6 retire");
        step(0, 0, 0, 0, 1, 3, "R6 retire to zero");
        step(1, 7, 5, 1, 0, 0, "R8 probe no claim");
        step(1, 7, 5, 0, 0, 0, "R3 claim again");
        step(1, 7, 1, 0, 0, 0, "R5 store releases");
        step(1, 9, 5, 0, 0, 0, "R3 claim 9");
        step(1, 9, 5, 0, 1, 9, "R11 read plus retire");
        step(1, 9, 2, 0, 1, 9, "R11 release wins");
        // R10 saturation
        step(1, 5, 5, 0, 0, 0, "R3 claim 5");
        for (int i = 0; i < 254; i++) step(1, 5, 5, 0, 0, 0, "R10 fill");
        step(1, 5, 5, 0, 0, 0, "R10 saturated stall");
        for (int i = 0; i < 255; i++) step(0, 0, 0, 0, 1, 5, "R6 drain");
        // R7 and R9 error cases
        step(0, 0, 0, 0, 1, 4, "R7 retire with no owner");
        step(0, 0, 0, 0, 0, 0, "R12 sticky");
        do_reset();
        step(1, 2, 5, 0, 0, 0, "R3 claim 2");
        step(0, 0, 0, 0, 1, 6, "R7 retire wrong id");
        do_reset();
        step(1, 100, 5, 0, 0, 0, "R9 reserved id");
        do_reset();
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int pid, kind, dpid;
            bit v, pr, dv;
            int sel;
            sel  = int'($urandom % 64);
            pid  = (sel == 0) ? 100 : 1 + int'($urandom % 3);
            kind = int'($urandom % 7);
            if ($urandom % 2 == 0) kind = 5;
            v    = ($urandom % 8) != 0;
            pr   = ($urandom % 10) == 0;
            dv   = ($urandom % 4) == 0;
            dpid = (m_owner != 200 && ($urandom % 16) != 0) ? m_owner : 1 + int'($urandom % 3);
            if (dv && m_owner == 200 && ($urandom % 8) != 0) dv = 0;
            step(v, pid, kind, pr, dv, dpid, "R2 R4 R6 R11 random");
            if (m_fault != 0 && ($urandom % 50) == 0) do_reset();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule